// File: doc/BRIEF.md
# Multi-Format Audio Serial Output Port

This block sends a stereo audio stream out on a three-wire serial link: a bit clock, a word-select line and a data line. Two parallel sample sources feed it, and a select input picks one of them. The receiver samples data on the rising bit-clock edge. Each sample leaves MSB first, framed in one of several formats. The standard I2S format puts the MSB one slot after the word-select change. The MSB-justified format puts the MSB in the slot where word select changes. The LSB-justified formats, at 16, 18, 20 or 24 bits, place the last bit of the field in the final slot of the half-frame.

One mode input picks master or slave operation, and it can change while the block runs. In master mode the block divides its system clock to make the bit clock and word select. The division follows the system-clock-to-sample-rate ratio: 256x and 512x give 32 slots per half-frame, and 384x and 768x give 24. In slave mode the bit clock and word select come from outside, locked in frequency to the system clock. The block then only drives data and an output-enable flag that tells the pads to release the clock pins. It measures the slot count of each half-frame from the external word select, so that LSB-justified framing can find the end of the half-frame.

New samples, the source choice and the format are taken together at the start of each frame, which is the word-select change to the left channel. A change made in the middle of a frame therefore never splits a frame.

Top module: `audio_ser_out`

## Requirements
- R1: While reset is high, bck_o and ws_o read 1 and dout_o and clk_oe_o read 0 one clock after reset is first seen.
- R2: In master mode, ratio_i code 0 (256x) gives a bit clock period of 4 system clocks, code 2 (512x) gives 8, code 1 (384x) gives 8 and code 3 (768x) gives 16. Codes 0 and 2 give 32 slots per half-frame and codes 1 and 3 give 24. A new ratio is taken at the next word-select change.
- R3: In master mode ws_o changes only in the cycle where bck_o goes from 1 to 0.
- R4: fmt_i code 0 (I2S): slot 0 of each half-frame carries 0, slots 1 to 24 carry the 24-bit sample MSB first, and later slots carry 0.
- R5: fmt_i code 1 (MSB-justified, and the unused codes 6 and 7): slots 0 to 23 carry the sample MSB first and later slots carry 0.
- R6: fmt_i codes 2, 3, 4 and 5 (LSB-justified, N = 16, 18, 20, 24): the last N slots of a half-frame of length L carry sample bits [23:24-N] MSB first, so the final slot holds bit 24-N. Slots before L-N carry 0.
- R7: Word select low carries the left sample and high carries the right sample. Slot k is the value of dout_o at the k-th rising bit-clock edge after the word-select change, counting from 0.
- R8: sel_i at 0 sends src0_left/src0_right and at 1 sends src1_left/src1_right.
- R9: Samples, source choice and format are captured at the bit-clock falling edge where word select goes to 0. Changes at any other time affect only the following frame.
- R10: In slave mode clk_oe_o is 0, bck_o and ws_o hold 1, and the data is framed by bck_i and ws_i. The bck_i half period must be at least 6 system clocks. LSB-justified framing uses the slot count of the preceding half-frame. In master mode clk_oe_o is 1.
- R11: dout_o changes only in the clock after a bit-clock falling edge has been detected. In master mode this is the cycle in which bck_o falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| master_i | input | 1 | 1 = generate the bit clock and word select, 0 = follow external clocks |
| ratio_i | input | 2 | System clock to sample rate ratio: 0=256x, 1=384x, 2=512x, 3=768x |
| fmt_i | input | 3 | Frame format code (see R4 to R6) |
| sel_i | input | 1 | Source select |
| src0_left | input | SAMPLE_W | Source 0 left sample |
| src0_right | input | SAMPLE_W | Source 0 right sample |
| src1_left | input | SAMPLE_W | Source 1 left sample |
| src1_right | input | SAMPLE_W | Source 1 right sample |
| bck_i | input | 1 | External bit clock (slave mode) |
| ws_i | input | 1 | External word select (slave mode) |
| bck_o | output | 1 | Generated bit clock (master mode) |
| ws_o | output | 1 | Generated word select (master mode) |
| clk_oe_o | output | 1 | High when bck_o/ws_o should drive the pins |
| dout_o | output | 1 | Serial data |

## Verification
A wrong slot counter or a stale half-frame length shifts the whole word. The half-frame that ends at the next word-select change then fails to match bit for bit, so the fault shows within one half-frame, which is 24 to 64 bit clocks. A wrong divider count shows at once as a changed bit-clock period, or as a slot count of the half-frame other than 24 or 32. A left/right swap, a wrong source mux, or a capture taken at a time other than the frame start shows in the first frame whose two channels, two sources or two neighbouring configurations differ, because the bench uses random, distinct values for each.

// File: rtl/aso_pkg.sv
package aso_pkg;
  // frame format codes
  localparam logic [2:0] FMT_I2S   = 3'd0;
  localparam logic [2:0] FMT_MSBJ  = 3'd1;
  localparam logic [2:0] FMT_LSB16 = 3'd2;
  localparam logic [2:0] FMT_LSB18 = 3'd3;
  localparam logic [2:0] FMT_LSB20 = 3'd4;
  localparam logic [2:0] FMT_LSB24 = 3'd5;

  // system clocks per bit-clock half period at the 256x ratio
  localparam int BASE_HALF   = 2;
  localparam int BITS_WIDE   = 32;
  localparam int BITS_NARROW = 24;
  localparam int MAX_HALF_CLKS = 4 * BASE_HALF;

  function automatic int half_clks(logic [1:0] r);
    case (r)
      2'd0:       return BASE_HALF;
      2'd1, 2'd2: return 2 * BASE_HALF;
      default:    return 4 * BASE_HALF;
    endcase
  endfunction

  function automatic int half_bits(logic [1:0] r);
    return r[0] ? BITS_NARROW : BITS_WIDE;
  endfunction

  function automatic int lsb_len(logic [2:0] f);
    case (f)
      FMT_LSB16: return 16;
      FMT_LSB18: return 18;
      FMT_LSB20: return 20;
      default:   return 24;
    endcase
  endfunction
endpackage

// File: rtl/aso_master_gen.sv
module aso_master_gen
  import aso_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ratio_i,
  output logic       bck_o,
  output logic       ws_o,
  output logic       fall_o
);
  localparam int HC_W = $clog2(MAX_HALF_CLKS);
  localparam int BC_W = $clog2(BITS_WIDE);

  logic [HC_W-1:0] hcnt, hlim;
  logic [BC_W-1:0] bcnt, blim;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt   <= '0;
      hlim   <= HC_W'(half_clks(ratio_i) - 1);
      blim   <= BC_W'(half_bits(ratio_i) - 1);
      bcnt   <= BC_W'(half_bits(ratio_i) - 1);
      bck_o  <= 1'b1;
      ws_o   <= 1'b1;
      fall_o <= 1'b0;
    end else begin
      fall_o <= 1'b0;
      if (hcnt == hlim) begin
        hcnt  <= '0;
        bck_o <= ~bck_o;
        if (bck_o) begin
          fall_o <= 1'b1;
          if (bcnt == blim) begin
            bcnt <= '0;
            ws_o <= ~ws_o;
            hlim <= HC_W'(half_clks(ratio_i) - 1);
            blim <= BC_W'(half_bits(ratio_i) - 1);
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  // R3
  ws_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (ws_o != $past(ws_o)) |-> ($past(bck_o) && !bck_o));

  // R2
  half_cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    hcnt <= hlim);
endmodule

// File: rtl/aso_slave_track.sv
module aso_slave_track (
  input  logic clk,
  input  logic rst,
  input  logic bck_i,
  input  logic ws_i,
  output logic fall_o,
  output logic ws_o
);
  logic [2:0] bsh;
  logic [1:0] wsh;

  always_ff @(posedge clk) begin
    if (rst) begin
      bsh    <= 3'b111;
      wsh    <= 2'b11;
      fall_o <= 1'b0;
      ws_o   <= 1'b1;
    end else begin
      bsh    <= {bsh[1:0], bck_i};
      wsh    <= {wsh[0], ws_i};
      fall_o <= bsh[2] & ~bsh[1];
      ws_o   <= wsh[1];
    end
  end
endmodule

// File: rtl/aso_serializer.sv
module aso_serializer
  import aso_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int MAX_HALF = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fall_i,
  input  logic                ws_i,
  input  logic [2:0]          fmt_i,
  input  logic                sel_i,
  input  logic [SAMPLE_W-1:0] s0_l,
  input  logic [SAMPLE_W-1:0] s0_r,
  input  logic [SAMPLE_W-1:0] s1_l,
  input  logic [SAMPLE_W-1:0] s1_r,
  output logic                dout_o
);
  localparam int POS_W = $clog2(MAX_HALF + 1);
  localparam logic [POS_W-1:0] POS_MAX = POS_W'(MAX_HALF);

  logic                ws_prev;
  logic [POS_W-1:0]    pos, hlen;
  logic [2:0]          cur_fmt;
  logic [SAMPLE_W-1:0] left_q, right_q;

  logic                ws_chg, frame_start, nbit;
  logic [POS_W-1:0]    slot, len_eff;
  logic [2:0]          fmt_eff;
  logic [SAMPLE_W-1:0] word;

  function automatic logic slot_bit(logic [2:0] f, logic [POS_W-1:0] len,
                                    logic [POS_W-1:0] s, logic [SAMPLE_W-1:0] w);
    int off;
    int n;
    logic [SAMPLE_W-1:0] sh;
    case (f)
      FMT_I2S: off = int'(s) - 1;
      FMT_LSB16, FMT_LSB18, FMT_LSB20, FMT_LSB24: begin
        n   = lsb_len(f);
        off = int'(s) - (int'(len) - n);
        if (off >= n) off = -1;
      end
      default: off = int'(s);
    endcase
    if (off < 0 || off >= SAMPLE_W) return 1'b0;
    sh = w << off;
    return sh[SAMPLE_W-1];
  endfunction

  always_comb begin
    ws_chg      = (ws_i != ws_prev);
    frame_start = fall_i & ws_chg & ~ws_i;
    slot        = ws_chg ? '0 : ((pos == POS_MAX) ? pos : pos + 1'b1);
    len_eff     = ws_chg ? pos + 1'b1 : hlen;
    fmt_eff     = frame_start ? fmt_i : cur_fmt;
    if (frame_start)  word = sel_i ? s1_l : s0_l;
    else if (ws_i)    word = right_q;
    else              word = left_q;
    nbit        = slot_bit(fmt_eff, len_eff, slot, word);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_prev <= 1'b1;
      pos     <= '0;
      hlen    <= POS_W'(BITS_WIDE);
      cur_fmt <= FMT_I2S;
      left_q  <= '0;
      right_q <= '0;
      dout_o  <= 1'b0;
    end else if (fall_i) begin
      ws_prev <= ws_i;
      pos     <= slot;
      dout_o  <= nbit;
      if (ws_chg) hlen <= len_eff;
      if (frame_start) begin
        cur_fmt <= fmt_i;
        left_q  <= sel_i ? s1_l : s0_l;
        right_q <= sel_i ? s1_r : s0_r;
      end
    end
  end

  // R11
  dout_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (dout_o != $past(dout_o)) |-> $past(fall_i));

  // R9
  fmt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cur_fmt != $past(cur_fmt)) |-> $past(frame_start));
endmodule

// File: rtl/audio_ser_out.sv
module audio_ser_out #(
  parameter int SAMPLE_W = 24,
  parameter int MAX_HALF = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                master_i,
  input  logic [1:0]          ratio_i,
  input  logic [2:0]          fmt_i,
  input  logic                sel_i,
  input  logic [SAMPLE_W-1:0] src0_left,
  input  logic [SAMPLE_W-1:0] src0_right,
  input  logic [SAMPLE_W-1:0] src1_left,
  input  logic [SAMPLE_W-1:0] src1_right,
  input  logic                bck_i,
  input  logic                ws_i,
  output logic                bck_o,
  output logic                ws_o,
  output logic                clk_oe_o,
  output logic                dout_o
);
  logic g_bck, g_ws, g_fall;
  logic s_fall, s_ws;
  logic fall_sel, ws_sel;

  aso_master_gen gen_i (
    .clk(clk), .rst(rst), .ratio_i(ratio_i),
    .bck_o(g_bck), .ws_o(g_ws), .fall_o(g_fall)
  );

  aso_slave_track trk_i (
    .clk(clk), .rst(rst), .bck_i(bck_i), .ws_i(ws_i),
    .fall_o(s_fall), .ws_o(s_ws)
  );

  assign fall_sel = master_i ? g_fall : s_fall;
  assign ws_sel   = master_i ? g_ws   : s_ws;

  aso_serializer #(.SAMPLE_W(SAMPLE_W), .MAX_HALF(MAX_HALF)) ser_i (
    .clk(clk), .rst(rst), .fall_i(fall_sel), .ws_i(ws_sel),
    .fmt_i(fmt_i), .sel_i(sel_i),
    .s0_l(src0_left), .s0_r(src0_right), .s1_l(src1_left), .s1_r(src1_right),
    .dout_o(dout_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bck_o    <= 1'b1;
      ws_o     <= 1'b1;
      clk_oe_o <= 1'b0;
    end else begin
      bck_o    <= master_i ? g_bck : 1'b1;
      ws_o     <= master_i ? g_ws  : 1'b1;
      clk_oe_o <= master_i;
    end
  end

  // R10
  slave_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !clk_oe_o |-> (bck_o && ws_o));
endmodule

// File: tb/audio_ser_out_tb_top.sv
module audio_ser_out_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW         = 24;
  localparam int SLV_HALF   = 6;
  localparam int SLV_BITS   = 64;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0, rst = 1'b1, master = 1'b1, sel = 1'b0;
  logic [1:0] ratio = 2'd0;
  logic [2:0] fmt = 3'd0;
  logic [SW-1:0] s0l = '0, s0r = '0, s1l = '0, s1r = '0;
  logic bck_in = 1'b1, ws_in = 1'b1;
  logic bck_o, ws_o, clk_oe, dout;

  int checks = 0, errors = 0;
  bit done = 0;

  // receiver model state
  bit mst = 1;
  int skip = 3, exp_len = 32, exp_per = 4;
  logic pb = 1'b1, pw = 1'b1, half_ws = 1'b1;
  logic [63:0] rx_word = '0;
  int cnt = 0, clk_cnt = 0, per = 0;
  logic [2:0] cur_fmt = 3'd0, prv_fmt = 3'd0;
  logic [SW-1:0] cur_l = '0, cur_r = '0, prv_r = '0;
  event frame_ev;
  int shc = 0, sbc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_ser_out dut_i (
    .clk(clk), .rst(rst), .master_i(master), .ratio_i(ratio), .fmt_i(fmt),
    .sel_i(sel), .src0_left(s0l), .src0_right(s0r), .src1_left(s1l),
    .src1_right(s1r), .bck_i(bck_in), .ws_i(ws_in), .bck_o(bck_o),
    .ws_o(ws_o), .clk_oe_o(clk_oe), .dout_o(dout)
  );

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // expected slot value per R4, R5, R6
  function automatic logic exp_bit(logic [2:0] f, int len, int p, logic [SW-1:0] w);
    int first, n;
    case (f)
      3'd0: begin first = 1; n = SW; end
      3'd2: begin n = 16; first = len - n; end
      3'd3: begin n = 18; first = len - n; end
      3'd4: begin n = 20; first = len - n; end
      3'd5: begin n = 24; first = len - n; end
      default: begin first = 0; n = SW; end
    endcase
    if (p < first || p >= first + n) return 1'b0;
    return w[SW-1-(p-first)];
  endfunction

  function automatic string fmt_tag(logic [2:0] f);
    if (f == 3'd0) return "R4";
    if (f == 3'd1) return "R5";
    return "R6";
  endfunction

  task automatic finish_half();
    logic [2:0] f;
    logic [SW-1:0] w;
    logic [63:0] e;
    if (skip > 0) begin
      skip--;
    end else begin
      f = half_ws ? prv_fmt : cur_fmt;   // R7: high = right of previous capture
      w = half_ws ? prv_r : cur_l;
      check(cnt == exp_len, "R2 slots per half-frame", 64'(cnt), 64'(exp_len));
      e = '0;
      for (int p = 0; p < cnt; p++) e = {e[62:0], exp_bit(f, cnt, p, w)};
      check(rx_word == e, {fmt_tag(f), " R7 R8 R9", mst ? "" : " R10", " half-frame word"},
            rx_word, e);
      if (mst) check(per == exp_per, "R2 bit clock period", 64'(per), 64'(exp_per));
    end
  endtask

  // slave-mode clock source: half period SLV_HALF clocks, SLV_BITS slots per half
  initial begin
    forever begin
      @(posedge clk); #1;
      shc++;
      if (shc == SLV_HALF) begin
        shc = 0;
        if (bck_in) begin
          bck_in = 1'b0;
          sbc++;
          if (sbc == SLV_BITS) begin sbc = 0; ws_in = ~ws_in; end
        end else begin
          bck_in = 1'b1;
        end
      end
    end
  end

  // receiver: samples away from the active edge
  initial begin
    logic b, w;
    forever begin
      @(negedge clk);
      if (!rst) begin
        b = mst ? bck_o : bck_in;
        w = mst ? ws_o : ws_in;
        clk_cnt++;
        if (mst && skip == 0 && w != pw)   // R3
          check(pb && !b, "R3 word select moved without bit clock fall", 64'(b), 64'(0));
        if (pb && !b && pw && !w) begin
          prv_fmt = cur_fmt; prv_r = cur_r;
          cur_fmt = fmt;
          cur_l   = sel ? s1l : s0l;
          cur_r   = sel ? s1r : s0r;
          -> frame_ev;
        end
        if (!pb && b) begin
          per = clk_cnt; clk_cnt = 0;
          if (w != half_ws) begin
            finish_half();
            half_ws = w; cnt = 0; rx_word = '0;
          end
          rx_word = {rx_word[62:0], dout};
          cnt++;
        end
        pb = b; pw = w;
      end
    end
  end

  task automatic run_frames(int n, bit directed);
    for (int i = 0; i < n; i++) begin
      @(frame_ev);
      repeat (8) @(posedge clk);
      #1;
      if (directed) begin
        case (i % 4)
          0: begin fmt = 3'd2; sel = 0; s0l = 24'hFFFFFF; s0r = 24'h00ABCD; s1l = 24'h111111; s1r = 24'h222222; end
          1: begin fmt = 3'd0; sel = 1; s1l = 24'h800001; s1r = 24'h7FFFFE; s0l = 24'h0; s0r = 24'h0; end
          2: begin fmt = 3'd5; sel = 0; s0l = 24'hA5A5A5; s0r = 24'h5A5A5A; end
          default: begin fmt = 3'd1; sel = 1; s1l = 24'h000000; s1r = 24'hFFFFFF; end
        endcase
      end else begin
        fmt = 3'($urandom_range(0, 5));
        sel = 1'($urandom_range(0, 1));
        s0l = 24'($urandom); s0r = 24'($urandom);
        s1l = 24'($urandom); s1r = 24'($urandom);
      end
    end
  endtask

  task automatic set_ratio(logic [1:0] r);
    @(frame_ev);
    repeat (8) @(posedge clk);
    #1;
    ratio = r;
    exp_len = r[0] ? 24 : 32;
    exp_per = (r == 2'd0) ? 4 : (r == 2'd3) ? 16 : 8;
    skip = 3;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    // R1
    check(bck_o == 1'b1, "R1 reset bck_o", 64'(bck_o), 64'(1));
    check(ws_o == 1'b1, "R1 reset ws_o", 64'(ws_o), 64'(1));
    check(dout == 1'b0, "R1 reset dout_o", 64'(dout), 64'(0));
    check(clk_oe == 1'b0, "R1 reset clk_oe_o", 64'(clk_oe), 64'(0));
    @(posedge clk); #1;
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(clk_oe == 1'b1, "R10 master drives clocks", 64'(clk_oe), 64'(1));

    run_frames(4, 1'b1);
    run_frames(10, 1'b0);
    for (int r = 1; r < 4; r++) begin
      set_ratio(2'(r));
      run_frames(6, 1'b0);
    end
    set_ratio(2'd0);
    run_frames(3, 1'b1);

    // slave mode
    @(frame_ev);
    repeat (8) @(posedge clk); #1;
    master = 1'b0; mst = 0; skip = 4; exp_len = SLV_BITS;
    repeat (3) @(negedge clk);
    check(clk_oe == 1'b0, "R10 slave releases clocks", 64'(clk_oe), 64'(0));
    run_frames(4, 1'b1);
    run_frames(6, 1'b0);
    check(bck_o == 1'b1 && ws_o == 1'b1, "R10 slave clocks held high",
          64'({bck_o, ws_o}), 64'(3));

    // back to master
    @(frame_ev);
    repeat (8) @(posedge clk); #1;
    master = 1'b1; mst = 1; skip = 4; exp_len = 32; exp_per = 4;
    run_frames(6, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1-flow: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule